// File: doc/BRIEF.md
# Serial Converter Command and Result Front End

This block is the bus-facing digital logic of a two-channel, 12-bit successive-approximation converter. It runs on the chip's system clock and oversamples the chip select, serial clock and serial data-in lines. It finds the rising and falling serial clock edges itself. These three inputs must already be synchronous to `clk`. A frame opens when chip select falls. The block skips any zeros that come before the start bit. It then takes three configuration bits, in this order: single/differential, odd/sign and replay. While the analog side samples, the block raises a registered sample-enable strobe. It also holds the channel and polarity selection as registered outputs.

The analog side presents a finished conversion on two parallel result ports, one per channel. In pseudo-differential mode, it places the difference for the chosen polarity on the port whose index equals the odd/sign bit. The block latches the chosen port when the sample window closes. It drives a low null bit, then the word MSB-first, then an optional LSB-first replay, then zeros until chip select rises. The output enable models the tristate pin, and `sdo` reads 0 whenever it is low. The result ports are plain level inputs that are read once per frame, so they carry no handshake and apply no back-pressure.

Top module: `adc_serial_frontend`

## Requirements
- R1: After reset the block is locked. With chip select held low from reset, no serial activity raises `sample_en` or `sdo_oe`. Chip select must go high and then low before a command is taken.
- R2: Within a frame, the first serial clock rise that sees `sdi` = 1 is the start bit. Any rises with `sdi` = 0 before it are ignored.
- R3: The next three rises capture, in order: `sel_single` (1 = single-ended, 0 = pseudo-differential), `sel_odd` (channel or polarity), and the replay bit. Result port `ch1_result` is used when `sel_odd` = 1, and `ch0_result` when it is 0.
- R4: `sample_en` rises on the second rise after the start bit. It falls on the serial clock fall that follows the third rise after the start bit.
- R5: On that same fall, `sdo_oe` goes to 1 and `sdo` drives a 0 null bit. Before it, `sdo_oe` is 0 during the frame.
- R6: The next 12 falls drive result bits 11 down to 0.
- R7: With the replay bit at 1, the next 11 falls drive bits 1 up to 11, and every later fall drives 0. With the replay bit at 0, every fall after bit 0 drives 0.
- R8: `sdo` changes only on serial clock falls, or when chip select rises. It never changes on a rise.
- R9: The result word is captured at the window-closing fall. Later changes on the result ports do not alter the stream.
- R10: When chip select rises, within one clock `sdo_oe`, `sdo` and `sample_en` go to 0 and `standby` goes to 1. The frame then ends, even if it is mid-stream. `standby` is 0 while a frame is open.
- R11: `sdi` values after the replay bit have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| sdi | input | 1 | Serial data in, sampled on serial clock rises |
| ch0_result | input | 12 | Conversion result for channel index 0 |
| ch1_result | input | 12 | Conversion result for channel index 1 |
| sample_en | output | 1 | Sample window strobe toward the analog side |
| sel_single | output | 1 | 1 = single-ended, 0 = pseudo-differential |
| sel_odd | output | 1 | Channel (single-ended) or polarity (differential) |
| standby | output | 1 | High when no frame is open |
| sdo | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe | output | 1 | Output enable of the serial data pin |

## Verification
The serial clock fall that closes the sample window is the same fall that captures the result word and drives the null bit. Three things therefore happen in one system clock: `sample_en` falls, `sdo_oe` rises and the word is latched. The bench provokes this in every frame. It checks that `sample_en` is low and `sdo_oe` high, with a 0 null bit, at the first sample after that fall. It then inverts both result ports partway through the stream and checks that every following bit still matches the word captured at the close.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam int CFG_BITS = 3;
  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_IDLE,
    ST_HUNT,
    ST_CONFIG,
    ST_STREAM
  } fe_state_t;
endpackage

// File: rtl/sclk_edge_detect.sv
module sclk_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
  import adc_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sdi,
  input  logic rise,
  input  logic fall,
  output logic sample_en,
  output logic sel_single,
  output logic sel_odd,
  output logic lsb_replay,
  output logic window_close,
  output logic standby
);
  localparam int CNT_W = $clog2(CFG_BITS + 1);

  fe_state_t        state;
  logic [CNT_W-1:0] cfg_cnt;

  assign window_close = !cs_n && (state == ST_CONFIG) &&
                        (cfg_cnt == CNT_W'(CFG_BITS)) && fall;
  assign standby = (state == ST_LOCKED) || (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_LOCKED;
      cfg_cnt    <= '0;
      sample_en  <= 1'b0;
      sel_single <= 1'b0;
      sel_odd    <= 1'b0;
      lsb_replay <= 1'b0;
    end else if (cs_n) begin
      state     <= ST_IDLE;
      cfg_cnt   <= '0;
      sample_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_HUNT;
        ST_HUNT: begin
          if (rise && sdi) begin
            state   <= ST_CONFIG;
            cfg_cnt <= '0;
          end
        end
        ST_CONFIG: begin
          if (rise && (cfg_cnt != CNT_W'(CFG_BITS))) begin
            cfg_cnt <= cfg_cnt + 1'b1;
            if (cfg_cnt == CNT_W'(0)) sel_single <= sdi;
            if (cfg_cnt == CNT_W'(1)) begin
              sel_odd   <= sdi;
              sample_en <= 1'b1;
            end
            if (cfg_cnt == CNT_W'(2)) lsb_replay <= sdi;
          end else if (window_close) begin
            sample_en <= 1'b0;
            state     <= ST_STREAM;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R4
  sample_open_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_en) |-> $past(rise));

  // R10
  sample_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !sample_en);
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fall,
  input  logic             window_close,
  input  logic             sel_odd,
  input  logic             lsb_replay,
  input  logic [RES_W-1:0] ch0_result,
  input  logic [RES_W-1:0] ch1_result,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int LAST_IDX = 2 * RES_W - 1;
  localparam int IDX_W    = $clog2(LAST_IDX + 2);

  logic [RES_W-1:0] word;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;

  function automatic logic bit_at(input int m, input logic [RES_W-1:0] w,
                                  input logic rep);
    logic [RES_W-1:0] t;
    t = '0;
    if (m >= 1 && m <= RES_W)                t = w >> (RES_W - m);
    else if (rep && m > RES_W && m <= LAST_IDX) t = w >> (m - RES_W);
    return t[0];
  endfunction

  assign idx_nxt = (idx == IDX_W'(LAST_IDX + 1)) ? idx : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      idx    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_n) begin
      idx    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (window_close) begin
      word   <= sel_odd ? ch1_result : ch0_result;
      idx    <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b1;
    end else if (sdo_oe && fall) begin
      idx <= idx_nxt;
      sdo <= bit_at(int'(idx_nxt), word, lsb_replay);
    end
  end

  // R8
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(fall) || $past(cs_n)));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe)) |-> $stable(word));

  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (!sdo_oe && !sdo));
endmodule

// File: rtl/adc_serial_frontend.sv
module adc_serial_frontend
  import adc_fe_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [RES_W-1:0] ch0_result,
  input  logic [RES_W-1:0] ch1_result,
  output logic             sample_en,
  output logic             sel_single,
  output logic             sel_odd,
  output logic             standby,
  output logic             sdo,
  output logic             sdo_oe
);
  logic rise, fall, window_close, lsb_replay;

  sclk_edge_detect edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  adc_cmd_decoder dec_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sdi         (sdi),
    .rise        (rise),
    .fall        (fall),
    .sample_en   (sample_en),
    .sel_single  (sel_single),
    .sel_odd     (sel_odd),
    .lsb_replay  (lsb_replay),
    .window_close(window_close),
    .standby     (standby)
  );

  adc_result_shifter #(.RES_W(RES_W)) shf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .fall        (fall),
    .window_close(window_close),
    .sel_odd     (sel_odd),
    .lsb_replay  (lsb_replay),
    .ch0_result  (ch0_result),
    .ch1_result  (ch1_result),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe)
  );

  // R5
  null_with_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> ($fell(sample_en) && !sdo));

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!sdo_oe && !sample_en));
endmodule

// File: tb/adc_serial_frontend_tb_top.sv
module adc_serial_frontend_tb_top;
  localparam int W = 12;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic [W-1:0] ch0, ch1;
  logic sample_en, sel_single, sel_odd, standby, sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_frontend #(.RES_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ch0_result(ch0), .ch1_result(ch1),
    .sample_en(sample_en), .sel_single(sel_single), .sel_odd(sel_odd),
    .standby(standby), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input int j, input logic [W-1:0] w, input bit rep);
    if (j >= 1 && j <= W) return w[W-j];
    if (rep && j > W && j <= 2*W-1) return w[j-W];
    return 1'b0;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input bit mode1, input int lead, input bit sgl,
                           input bit odd, input bit rep, input logic [W-1:0] a,
                           input logic [W-1:0] b, input int swap_at, input int nclk);
    logic [W-1:0] word;
    int s, total, j;
    string tg;
    ch0 = a; ch1 = b; sclk = mode1; sdi = 1'b0;
    wait_n(3);
    cs_n = 1'b0;
    wait_n(3);
    chk(standby == 1'b0, "R10 standby in frame", standby, 0);
    word = odd ? b : a;
    s = lead;
    total = (nclk > 0) ? nclk : s + 4 + 2*W + 2;
    for (int k = 0; k < total; k++) begin
      sclk = 1'b0;
      if (k < s)            sdi = 1'b0;
      else if (k == s)      sdi = 1'b1;
      else if (k == s + 1)  sdi = sgl;
      else if (k == s + 2)  sdi = odd;
      else if (k == s + 3)  sdi = rep;
      else                  sdi = k[0];  // R11 don't-care pattern
      wait_n(H);
      j = k - (s + 4);
      if (j < 0) begin
        chk(sdo_oe == 1'b0, "R5 oe low before null", sdo_oe, 0);
      end else begin
        if (j == 0)       tg = "R5 null bit";
        else if (j <= W)  tg = "R6 msb-first bit";
        else              tg = "R7 replay/zero bit";
        chk(sdo_oe == 1'b1, tg, sdo_oe, 1);
        chk(sdo == exp_bit(j, word, rep), tg, sdo, exp_bit(j, word, rep));
      end
      chk(sample_en == (k == s + 3), "R4 sample low phase", sample_en, (k == s + 3));
      if (swap_at >= 0 && j == swap_at) begin
        ch0 = ~a;  // R9 late change
        ch1 = ~b;
      end
      sclk = 1'b1;
      wait_n(H);
      chk(sample_en == (k == s + 2 || k == s + 3), "R4 sample high phase",
          sample_en, (k == s + 2 || k == s + 3));
      if (j >= 0)
        chk(sdo == exp_bit(j, word, rep), "R8 no change on rise", sdo,
            exp_bit(j, word, rep));
    end
    chk(sel_single == sgl, "R3 sel_single", sel_single, sgl);
    chk(sel_odd == odd, "R3 sel_odd", sel_odd, odd);
    if (!mode1) sclk = 1'b0;
    wait_n(H);
    cs_n = 1'b1;
    wait_n(2);
    chk(sdo_oe == 1'b0, "R10 oe off", sdo_oe, 0);
    chk(sdo == 1'b0, "R10 sdo off", sdo, 0);
    chk(standby == 1'b1, "R10 standby", standby, 1);
    chk(sample_en == 1'b0, "R10 sample off", sample_en, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; sdi = 1'b0; ch0 = '0; ch1 = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk(standby == 1'b1, "R10 reset standby", standby, 1);
    chk(sdo_oe == 1'b0, "R10 reset oe", sdo_oe, 0);
    chk(sdo == 1'b0, "R10 reset sdo", sdo, 0);
    chk(sample_en == 1'b0, "R10 reset sample", sample_en, 0);
    // R1: chip select low since reset, full command clocked in
    ch0 = 12'hA5C;
    for (int k = 0; k < 30; k++) begin
      sclk = 1'b0;
      sdi = (k < 4) ? 1'b1 : k[1];
      wait_n(H);
      chk(sdo_oe == 1'b0, "R1 locked oe", sdo_oe, 0);
      sclk = 1'b1;
      wait_n(H);
      chk(sample_en == 1'b0, "R1 locked sample", sample_en, 0);
    end
    sclk = 1'b0;
    cs_n = 1'b1;
    wait_n(4);
    // R2 R6 R7 sweep over lead zeros, mode, config and replay
    for (int m = 0; m < 2; m++)
      for (int lead = 0; lead < 8; lead++)
        for (int cfg = 0; cfg < 8; cfg++) begin
          logic [W-1:0] a, b;
          a = W'((lead * 1237 + cfg * 311 + m * 97 + 12'h5A5) & 12'hFFF);
          b = W'(~a ^ W'(cfg * 77 + lead));
          run_frame(m[0], lead, cfg[2], cfg[1], cfg[0], a, b,
                    (cfg == 3) ? 5 : -1, 0);
        end
    // boundary words
    run_frame(1'b0, 0, 1'b1, 1'b0, 1'b1, 12'hFFF, 12'h000, -1, 0);
    run_frame(1'b1, 2, 1'b1, 1'b1, 1'b1, 12'hFFF, 12'h000, 3, 0);
    run_frame(1'b0, 1, 1'b0, 1'b1, 1'b0, 12'h000, 12'h801, 12, 0);
    // R10 abort mid-stream, then a clean frame afterwards
    run_frame(1'b0, 3, 1'b1, 1'b0, 1'b1, 12'h3C6, 12'h111, -1, 3 + 4 + 6);
    run_frame(1'b0, 0, 1'b1, 1'b1, 1'b1, 12'h3C6, 12'h9E2, -1, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule